// File: doc/BRIEF.md
# Block-Ack Window Tracker

This block follows the delivery state of one aggregated transmit queue. It keeps a sliding window of up to 64 consecutive 12-bit sequence numbers, and for each slot in that window it holds two bits: the frame has gone out, and the frame has been acknowledged. Two event inputs change that state. A send event carries the sequence number of a frame that has just been transmitted. A block-ack event carries a starting sequence number and a 64-bit bitmap, where bit i refers to the starting number plus i, modulo 4096.

The block has three outputs. A completion output, registered, reports in one cycle every frame that a block-ack has newly acknowledged, as a mask relative to a base sequence number. That mask need not be contiguous, so frames complete out of order. A retransmit stream, under valid/ready, names the frames a block-ack covered but left unacknowledged, lowest sequence first. The window start moves only past the contiguous run of acknowledged slots at its bottom. A send event that cannot be accepted raises a one-cycle error flag and is dropped. Two 7-bit configuration fields set the usable window size and the maximum number of frames that may be outstanding.

Top module: `ba_window_tracker`

## Requirements
- R1: After a synchronous reset the window start is 0. No retransmit request, completion or error is signalled, and all slots are empty.
- R2: A send event with offset o = (snd_seq − win_start) mod 4096 below the effective window size marks slot o as sent. The effective window size is cfg_win_size, limited to 64.
- R3: A bitmap bit whose slot is not marked sent, or whose sequence number falls outside the 64-slot window, is ignored. It produces no completion and does not move the window.
- R4: After a block-ack, the window start advances by the length of the run of acknowledged slots that begins at offset 0. Every slot passed over is emptied and can take a new frame.
- R5: One cycle after a block-ack, done_valid is high if any sent slot was newly acknowledged. done_base is the window start from before the event. Bit j of done_mask marks the frame done_base + j, and gaps in the mask are allowed.
- R6: A send event whose offset is at or above the effective window size raises snd_err for one cycle, one cycle later. The event is otherwise ignored, so a later block-ack bit for that sequence number produces no completion.
- R7: A send event to an empty slot while the number of sent-but-unacknowledged slots is at least cfg_frame_limit raises snd_err and is ignored. A repeated send to a slot that is already sent is never an error.
- R8: Each sent, unacknowledged slot that a block-ack covers becomes a pending retransmit. rtx_valid stays high while any retransmit is pending. rtx_seq names the pending frame with the lowest offset and holds steady while rtx_ready is low. A transfer with rtx_ready high removes that frame, and a later acknowledgement also removes it.
- R9: All sequence arithmetic wraps modulo 4096. The window and the bitmap may straddle 4095 to 0.
- R10: A block-ack whose start lies up to 63 below the window start is applied with bit i still meaning start + i. Bits that fall below the window are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_size | input | 7 | Usable window size; values above 64 act as 64 |
| cfg_frame_limit | input | 7 | Maximum number of sent, unacknowledged frames |
| snd_valid | input | 1 | Send event strobe |
| snd_seq | input | 12 | Sequence number of the frame that was sent |
| ack_valid | input | 1 | Block-ack event strobe |
| ack_ssn | input | 12 | Starting sequence number of the block-ack |
| ack_bitmap | input | 64 | Acknowledgement bits; bit i refers to ack_ssn + i |
| rtx_valid | output | 1 | A retransmit request is pending |
| rtx_ready | input | 1 | Consumer takes the current retransmit request |
| rtx_seq | output | 12 | Sequence number to retransmit |
| done_valid | output | 1 | Completion report is present this cycle |
| done_base | output | 12 | Sequence number that bit 0 of done_mask refers to |
| done_mask | output | 64 | Newly acknowledged frames, relative to done_base |
| win_start | output | 12 | Current window start sequence number |
| snd_err | output | 1 | Previous send event was rejected |

## Verification
Directed patterns cover four block-ack cases. A gapped bitmap separates out-of-order completion from sliding of the window. A bitmap over unsent slots shows that such bits are ignored. A bitmap whose start lies below the window checks the alignment shift in the other direction. A run of full windows drives the sequence numbers across the 4095-to-0 wrap. Send events at the edge of a reduced window size, and at a reduced frame limit, tell the two rejection causes apart, and a repeated send shows that a full limit does not block a slot that is already sent. A long random phase then mixes overlapping send and block-ack events, random ready back-pressure, clamped window sizes and both directions of bitmap offset. This exposes ordering faults that only appear when events fall in the same cycle.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned SEQ_BITS = 12;
  localparam int unsigned SLOTS    = 64;
endpackage

// File: rtl/bat_align.sv
// Maps a block-ack bitmap onto window offsets and marks which offsets it covers.
module bat_align #(
  parameter int unsigned SEQ_W = 12,
  parameter int unsigned WIN   = 64
) (
  input  logic             en,
  input  logic [SEQ_W-1:0] ssn,
  input  logic [SEQ_W-1:0] base,
  input  logic [WIN-1:0]   bmp,
  output logic [WIN-1:0]   aligned,
  output logic [WIN-1:0]   covered
);
  logic [SEQ_W-1:0] ahead;
  logic [SEQ_W-1:0] behind;
  localparam logic [WIN-1:0] ONES = '1;

  assign ahead  = ssn - base;
  assign behind = base - ssn;

  always_comb begin
    aligned = '0;
    covered = '0;
    if (en) begin
      if (ahead < SEQ_W'(WIN)) begin
        aligned = bmp << ahead;
        covered = ONES << ahead;
      end else if (behind < SEQ_W'(WIN)) begin
        aligned = bmp >> behind;
        covered = ONES >> behind;
      end
    end
  end
endmodule

// File: rtl/bat_lead_ones.sv
// Length of the run of ones starting at bit 0.
module bat_lead_ones #(
  parameter int unsigned WIN = 64,
  localparam int unsigned CW = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0] vec,
  output logic [CW-1:0]  run
);
  logic [WIN:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < WIN; i++) begin : g_chain
    assign chain[i+1] = chain[i] & vec[i];
  end

  always_comb begin
    run = '0;
    for (int i = 1; i <= WIN; i++) run = run + CW'(chain[i]);
  end
endmodule

// File: rtl/bat_lowest.sv
// Index of the lowest set bit.
module bat_lowest #(
  parameter int unsigned WIN = 64,
  localparam int unsigned IW = $clog2(WIN)
) (
  input  logic [WIN-1:0] vec,
  output logic           any,
  output logic [IW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker #(
  parameter int unsigned SEQ_W = bat_pkg::SEQ_BITS,
  parameter int unsigned WIN   = bat_pkg::SLOTS,
  localparam int unsigned CW   = $clog2(WIN + 1),
  localparam int unsigned IW   = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cfg_win_size,
  input  logic [CW-1:0]    cfg_frame_limit,
  input  logic             snd_valid,
  input  logic [SEQ_W-1:0] snd_seq,
  input  logic             ack_valid,
  input  logic [SEQ_W-1:0] ack_ssn,
  input  logic [WIN-1:0]   ack_bitmap,
  output logic             rtx_valid,
  input  logic             rtx_ready,
  output logic [SEQ_W-1:0] rtx_seq,
  output logic             done_valid,
  output logic [SEQ_W-1:0] done_base,
  output logic [WIN-1:0]   done_mask,
  output logic [SEQ_W-1:0] win_start,
  output logic             snd_err
);
  // per-slot state, indexed by offset from win_start
  logic [WIN-1:0] sent_q, acked_q, pend_q;

  // send acceptance
  logic [CW-1:0]    lim;
  logic [SEQ_W-1:0] snd_off;
  logic             in_win, slot_free, err_n;
  logic [CW-1:0]    outst;
  logic [WIN-1:0]   sent1;

  assign lim       = (cfg_win_size > CW'(WIN)) ? CW'(WIN) : cfg_win_size;
  assign snd_off   = snd_seq - win_start;
  assign in_win    = snd_off < SEQ_W'(lim);
  assign slot_free = ~sent_q[snd_off[IW-1:0]];

  always_comb begin
    outst = '0;
    for (int i = 0; i < WIN; i++) outst = outst + CW'(sent_q[i] & ~acked_q[i]);
  end

  assign err_n = snd_valid && (!in_win || (slot_free && (outst >= cfg_frame_limit)));

  always_comb begin
    sent1 = sent_q;
    if (snd_valid && !err_n) sent1[snd_off[IW-1:0]] = 1'b1;
  end

  // retransmit selection
  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic [WIN-1:0] pend0;

  bat_lowest #(.WIN(WIN)) u_pick (.vec(pend_q), .any(pick_any), .idx(pick_idx));

  assign rtx_valid = pick_any;
  assign rtx_seq   = win_start + SEQ_W'(pick_idx);

  always_comb begin
    pend0 = pend_q;
    if (pick_any && rtx_ready) pend0[pick_idx] = 1'b0;
  end

  // block-ack application
  logic [WIN-1:0] ack_al, ack_cov, new_ack, acked1, pend1;

  bat_align #(.SEQ_W(SEQ_W), .WIN(WIN)) u_align (
    .en(ack_valid), .ssn(ack_ssn), .base(win_start), .bmp(ack_bitmap),
    .aligned(ack_al), .covered(ack_cov)
  );

  assign new_ack = ack_al & sent1 & ~acked_q;
  assign acked1  = acked_q | new_ack;
  assign pend1   = (pend0 | (ack_cov & sent1)) & ~acked1;

  // window slide
  logic [CW-1:0] slide;
  bat_lead_ones #(.WIN(WIN)) u_run (.vec(acked1), .run(slide));

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q     <= '0;
      acked_q    <= '0;
      pend_q     <= '0;
      win_start  <= '0;
      done_valid <= 1'b0;
      done_base  <= '0;
      done_mask  <= '0;
      snd_err    <= 1'b0;
    end else begin
      sent_q     <= sent1  >> slide;
      acked_q    <= acked1 >> slide;
      pend_q     <= pend1  >> slide;
      win_start  <= win_start + SEQ_W'(slide);
      done_valid <= |new_ack;
      done_base  <= win_start;
      done_mask  <= new_ack;
      snd_err    <= err_n;
    end
  end
endmodule

// File: rtl/bat_checker.sv
module bat_checker #(
  parameter int unsigned SEQ_W = 12,
  parameter int unsigned WIN   = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             snd_valid,
  input logic             ack_valid,
  input logic             rtx_valid,
  input logic             rtx_ready,
  input logic [SEQ_W-1:0] rtx_seq,
  input logic             done_valid,
  input logic [SEQ_W-1:0] done_base,
  input logic [SEQ_W-1:0] win_start,
  input logic             snd_err
);
  // R8: a stalled request is held when no block-ack can remove it
  assert_rtx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rtx_valid && !rtx_ready && !ack_valid) |=> (rtx_valid && $stable(rtx_seq)));

  // R5: completion base is the window start before the event
  assert_done_base_R5: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_base == $past(win_start)));

  // R3: completions only follow a block-ack
  assert_done_cause_R3: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(ack_valid));

  // R4: the window only moves after a block-ack
  assert_slide_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (win_start != $past(win_start)) |-> $past(ack_valid));

  // R6: an error only follows a send event
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    snd_err |-> $past(snd_valid));
endmodule

bind ba_window_tracker bat_checker #(.SEQ_W(SEQ_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst(rst), .snd_valid(snd_valid), .ack_valid(ack_valid),
  .rtx_valid(rtx_valid), .rtx_ready(rtx_ready), .rtx_seq(rtx_seq),
  .done_valid(done_valid), .done_base(done_base), .win_start(win_start),
  .snd_err(snd_err)
);

// File: tb/ba_window_tracker_tb.sv
`timescale 1ns/1ps
module ba_window_tracker_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  cws, cfl;
  logic        sv, bv, rdy;
  logic [11:0] ss, bs;
  logic [63:0] bm;
  logic        rtx_valid, done_valid, snd_err;
  logic [11:0] rtx_seq, done_base, win_start;
  logic [63:0] done_mask;

  always #10 clk = ~clk;

  ba_window_tracker u_dut (
    .clk(clk), .rst(rst), .cfg_win_size(cws), .cfg_frame_limit(cfl),
    .snd_valid(sv), .snd_seq(ss), .ack_valid(bv), .ack_ssn(bs), .ack_bitmap(bm),
    .rtx_valid(rtx_valid), .rtx_ready(rdy), .rtx_seq(rtx_seq),
    .done_valid(done_valid), .done_base(done_base), .done_mask(done_mask),
    .win_start(win_start), .snd_err(snd_err)
  );

  int unsigned n_vec = 0, n_bad = 0;

  // reference state, indexed by sequence number: 0 empty, 1 sent, 2 acked
  byte         m_st  [4096];
  bit          m_rtx [4096];
  logic [11:0] m_start, m_dbase;
  logic [63:0] m_dmask;
  bit          m_err;

  function automatic void m_reset();
    for (int i = 0; i < 4096; i++) begin m_st[i] = 0; m_rtx[i] = 0; end
    m_start = 0; m_dbase = 0; m_dmask = 0; m_err = 0;
  endfunction

  function automatic bit m_lowest(output logic [11:0] s);
    for (int o = 0; o < 64; o++) begin
      s = m_start + 12'(o);
      if (m_rtx[s]) return 1;
    end
    return 0;
  endfunction

  function automatic void m_step();
    logic [11:0] s, o;
    int lim, cnt;
    if (m_lowest(s) && rdy) m_rtx[s] = 0;
    m_err = 0;
    if (sv) begin
      o = ss - m_start;
      lim = (cws > 64) ? 64 : int'(cws);
      if (int'(o) >= lim) m_err = 1;
      else if (m_st[ss] == 0) begin
        cnt = 0;
        for (int k = 0; k < 64; k++) if (m_st[m_start + 12'(k)] == 1) cnt++;
        if (cnt >= int'(cfl)) m_err = 1; else m_st[ss] = 1;
      end
    end
    m_dmask = 0;
    m_dbase = m_start;
    if (bv) begin
      for (int i = 0; i < 64; i++) begin
        s = bs + 12'(i);
        o = s - m_start;
        if (o < 12'd64 && m_st[s] == 1) begin
          if (bm[i]) begin m_st[s] = 2; m_rtx[s] = 0; m_dmask[o[5:0]] = 1'b1; end
          else m_rtx[s] = 1;
        end
      end
    end
    for (int k = 0; k < 64; k++) begin
      if (m_st[m_start] != 2) break;
      m_st[m_start] = 0; m_rtx[m_start] = 0; m_start = m_start + 12'd1;
    end
  endfunction

  task automatic miss(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic compare(input string tag);
    logic [11:0] es;
    bit ev;
    n_vec++;
    ev = m_lowest(es);
    if (win_start !== m_start) miss(tag, "win_start", 64'(win_start), 64'(m_start));
    if (done_valid !== (|m_dmask)) miss(tag, "done_valid", 64'(done_valid), 64'(|m_dmask));
    if (done_mask !== m_dmask) miss(tag, "done_mask", done_mask, m_dmask);
    if (|m_dmask && done_base !== m_dbase) miss(tag, "done_base", 64'(done_base), 64'(m_dbase));
    if (snd_err !== m_err) miss(tag, "snd_err", 64'(snd_err), 64'(m_err));
    if (rtx_valid !== ev) miss(tag, "rtx_valid", 64'(rtx_valid), 64'(ev));
    if (ev && rtx_seq !== es) miss(tag, "rtx_seq", 64'(rtx_seq), 64'(es));
  endtask

  task automatic lit(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) miss(tag, "literal", act, exp);
  endtask

  // inputs already driven for this cycle; advance one cycle and check
  task automatic step(input string tag);
    m_step();
    @(negedge clk);
    compare(tag);
    sv = 0; bv = 0;
  endtask

  task automatic do_send(input logic [11:0] q, input string tag);
    sv = 1; ss = q; step(tag);
  endtask

  task automatic do_ack(input logic [11:0] q, input logic [63:0] b, input string tag);
    bv = 1; bs = q; bm = b; step(tag);
  endtask

  task automatic do_reset();
    rst = 1; sv = 0; bv = 0; rdy = 0; ss = 0; bs = 0; bm = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_reset();
    compare("R1");
    lit("R1", 64'(win_start), 64'd0);
  endtask

  initial begin
    cws = 7'd64; cfl = 7'd64;
    void'($urandom(32'd1234));
    do_reset();

    // R2 / R5 / R8: send 0..3, acknowledge 1 and 2 only
    for (int i = 0; i < 4; i++) do_send(12'(i), "R2");
    do_ack(12'd0, 64'h6, "R5");
    lit("R5", done_mask, 64'h6);
    lit("R5", 64'(win_start), 64'd0);
    lit("R8", 64'(rtx_seq), 64'd0);
    step("R8"); step("R8");
    lit("R8", 64'(rtx_seq), 64'd0);
    rdy = 1; step("R8");
    lit("R8", 64'(rtx_seq), 64'd3);
    step("R8");
    lit("R8", 64'(rtx_valid), 64'd0);
    rdy = 0;

    // R4: acknowledging 0 closes the run 0..2
    do_ack(12'd0, 64'h1, "R4");
    lit("R4", 64'(win_start), 64'd3);

    // R3: bit for unsent sequence 4
    do_ack(12'd3, 64'h2, "R3");
    lit("R3", 64'(done_valid), 64'd0);

    // R6: window reduced to 8
    cws = 7'd8;
    do_send(12'd11, "R6");
    lit("R6", 64'(snd_err), 64'd1);
    do_ack(12'd11, 64'h1, "R6");
    lit("R6", 64'(done_valid), 64'd0);
    do_send(12'd2, "R6");
    lit("R6", 64'(snd_err), 64'd1);
    do_send(12'd10, "R6");
    lit("R6", 64'(snd_err), 64'd0);
    cws = 7'd64;

    // R7: frame limit 3 (3 and 10 outstanding)
    cfl = 7'd3;
    do_send(12'd4, "R7");
    do_send(12'd5, "R7");
    lit("R7", 64'(snd_err), 64'd1);
    do_send(12'd3, "R7");
    lit("R7", 64'(snd_err), 64'd0);
    do_ack(12'd5, 64'h1, "R7");
    lit("R7", 64'(done_valid), 64'd0);
    cfl = 7'd64;

    // R10: bitmap starting two below the window (bits 2,3 hit 3,4)
    do_ack(12'd1, 64'hC, "R10");
    lit("R10", 64'(win_start), 64'd5);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 8);
      cws = (r == 0) ? 7'd40 : (r == 1) ? 7'd100 : 7'd64;
      cfl = (r == 2) ? 7'd30 : 7'd64;
      rdy = $urandom % 3 != 0;
      sv = $urandom % 4 != 0;
      ss = m_start + 12'($urandom % 72);
      bv = $urandom % 4 == 0;
      bs = m_start + 12'($urandom % 24) - 12'd8;
      bm = {$urandom, $urandom} | {$urandom, $urandom};
      step("R2 random");
    end

    // R9: wrap past 4095
    cws = 7'd64; cfl = 7'd64;
    do_reset();
    rdy = 1;
    for (int r2 = 0; r2 < 63; r2++) begin
      for (int i = 0; i < 64; i++) do_send(m_start + 12'(i), "R9");
      do_ack(m_start, '1, "R9");
    end
    lit("R9", 64'(win_start), 64'd4032);
    for (int i = 0; i < 64; i++) do_send(12'd4032 + 12'(i), "R9");
    do_ack(12'd4032, 64'hFFFF_FFFF, "R9");
    lit("R9", 64'(win_start), 64'd4064);
    for (int i = 0; i < 32; i++) do_send(12'(i), "R9");
    do_ack(12'd4064, '1, "R9");
    lit("R9", 64'(win_start), 64'd32);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule